// File: doc/BRIEF.md
# Two-Band Spectral Energy Bit Detector

This block sits behind an FFT core and turns each frame of spectrum bins into a single decision bit. Bins arrive one per beat on a valid/ready stream slave, each carrying a signed real part, a signed imaginary part and an end-of-frame marker. The block numbers the bins as they arrive. It then builds two band sums. One band lies around a low tone centre bin and the other around a high tone centre bin. Each band spans the centre plus or minus a window of bins. The energy of one bin is taken as the absolute value of its real part plus the absolute value of its imaginary part.

When the end-of-frame beat is accepted, the block compares the two sums. The bit goes to 1 only when the high band sum is strictly greater than an integer margin times the low band sum. Otherwise it goes to 0. The bit and both sums are registered together and held until the next frame ends, so a slow register readout sees a consistent set. A flag reports whether the last frame ended at a bin count other than the expected frame length. Only the lower half of the spectrum is considered, because the input to the FFT is real-valued. Defaults: 8192 bins per frame, centres at bins 655 and 1311.

Back-pressure rules: the block never applies back-pressure. Ready is held high at all times. A beat is taken on every clock where valid is high, and nothing is taken while valid is low, whatever the other inputs hold.

Top module: `tone_band_detector`

## Requirements
- R1: `s_tready` is 1 at every cycle. A cycle with `s_tvalid` low is ignored completely, even with `s_tlast` high: no output changes and no bin is counted.
- R2: Bin energy is |re| + |im|, with both parts in two's complement. The most negative input value counts as 2^(DATA_W-1).
- R3: `band_lo_sum` is the sum of energies of the bins with index in [CENTER_LO-WINDOW, CENTER_LO+WINDOW]. `band_hi_sum` is the same over [CENTER_HI-WINDOW, CENTER_HI+WINDOW]. Bin index 0 is the first beat of a frame.
- R4: Bins with index at or above FRAME_LEN/2 add nothing to either sum, even inside a band window.
- R5: `tone_bit` is 1 exactly when band_hi_sum > MARGIN × band_lo_sum. It is 0 on equality.
- R6: `tone_bit`, both sums and `frame_misaligned` update on the clock edge that accepts the end-of-frame beat, all in the same cycle. At all other times they hold their values.
- R7: Sums restart at the first beat of each frame, so no energy carries from one frame into the next.
- R8: `frame_misaligned` is 1 after a frame whose end-of-frame beat had a bin index other than FRAME_LEN-1, and 0 after a frame of exactly FRAME_LEN beats.
- R9: Sums never wrap. Full-scale negative values on every band bin give the exact sum (2·WINDOW+1)·2^DATA_W for a band that lies wholly below FRAME_LEN/2.
- R10: After reset, `tone_bit`, both sums and `frame_misaligned` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_tvalid | input | 1 | Bin beat valid |
| s_tready | output | 1 | Always 1; the stream is never stalled |
| s_tre | input | DATA_W | Signed real part of the bin |
| s_tim | input | DATA_W | Signed imaginary part of the bin |
| s_tlast | input | 1 | Marks the last bin of a frame |
| tone_bit | output | 1 | Frame decision: 1 when the high band dominates by the margin |
| band_lo_sum | output | SUM_W | Registered energy sum of the low band |
| band_hi_sum | output | SUM_W | Registered energy sum of the high band |
| frame_misaligned | output | 1 | Last frame ended at an unexpected bin count |

## Verification
Every result of this block is due on the single clock edge that accepts the end-of-frame beat. None of them is due earlier, and none is due at any other edge. The bench drives each beat just after a falling edge. After the last beat it drops valid at the next falling edge, which falls after the edge that took the beat, and reads all four results there. Mid-frame and during idle cycles with a stray end marker, it checks that the results still show the previous frame's values.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  // Width of one bin energy: two magnitudes of DATA_W bits each, summed.
  function automatic int energy_width(input int data_w);
    return data_w + 1;
  endfunction

  // Width that holds a full-scale band sum without wrapping.
  function automatic int sum_width(input int data_w, input int window);
    return data_w + 1 + $clog2(2 * window + 1);
  endfunction
endpackage

// File: rtl/tbd_bin_energy.sv
module tbd_bin_energy #(
  parameter int DATA_W = 16,
  localparam int E_W = tbd_pkg::energy_width(DATA_W)
) (
  input  logic signed [DATA_W-1:0] re,
  input  logic signed [DATA_W-1:0] im,
  output logic        [E_W-1:0]    energy
);
  logic [DATA_W-1:0] mag_re;
  logic [DATA_W-1:0] mag_im;

  // Negating the most negative value leaves its bit pattern, read unsigned as 2^(DATA_W-1).
  always_comb begin
    mag_re = re[DATA_W-1] ? DATA_W'(-re) : DATA_W'(re);
    mag_im = im[DATA_W-1] ? DATA_W'(-im) : DATA_W'(im);
    energy = E_W'(mag_re) + E_W'(mag_im);
  end
endmodule

// File: rtl/tbd_band_acc.sv
module tbd_band_acc #(
  parameter int BIN_W  = 13,
  parameter int CENTER = 655,
  parameter int WINDOW = 4,
  parameter int HALF   = 4096,
  parameter int E_W    = 17,
  parameter int S_W    = 21,
  localparam int LO_EDGE = (CENTER >= WINDOW) ? CENTER - WINDOW : 0,
  localparam int HI_EDGE = CENTER + WINDOW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             first,
  input  logic [BIN_W-1:0] bin,
  input  logic [E_W-1:0]   energy,
  output logic [S_W-1:0]   sum_next
);
  logic [S_W-1:0] acc;
  logic [S_W-1:0] base;
  logic [S_W:0]   wide;
  logic           hit;
  int             bin_i;

  always_comb begin
    bin_i = int'(bin);
    hit   = (bin_i >= LO_EDGE) && (bin_i <= HI_EDGE) && (bin_i < HALF);
    base  = first ? '0 : acc;
    wide  = {1'b0, base} + (hit ? (S_W + 1)'(energy) : '0);
    // Saturate as a guard; the sizing already keeps a full band below the top.
    sum_next = wide[S_W] ? '1 : wide[S_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (beat) acc <= sum_next;
  end
endmodule

// File: rtl/tbd_decide.sv
module tbd_decide #(
  parameter int S_W    = 21,
  parameter int MARGIN = 2,
  localparam int M_W = (MARGIN > 0) ? $clog2(MARGIN + 1) : 1,
  localparam int P_W = S_W + M_W
) (
  input  logic [S_W-1:0] lo_sum,
  input  logic [S_W-1:0] hi_sum,
  output logic           hi_wins
);
  logic [P_W-1:0] scaled_lo;
  logic [P_W-1:0] hi_ext;

  always_comb begin
    scaled_lo = P_W'(lo_sum) * P_W'(MARGIN);
    hi_ext    = P_W'(hi_sum);
    hi_wins   = hi_ext > scaled_lo;
  end
endmodule

// File: rtl/tone_band_detector.sv
module tone_band_detector #(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 8192,
  parameter int CENTER_LO = 655,
  parameter int CENTER_HI = 1311,
  parameter int WINDOW    = 4,
  parameter int MARGIN    = 2,
  localparam int BIN_W = $clog2(FRAME_LEN),
  localparam int E_W   = tbd_pkg::energy_width(DATA_W),
  localparam int SUM_W = tbd_pkg::sum_width(DATA_W, WINDOW)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_tvalid,
  output logic                     s_tready,
  input  logic signed [DATA_W-1:0] s_tre,
  input  logic signed [DATA_W-1:0] s_tim,
  input  logic                     s_tlast,
  output logic                     tone_bit,
  output logic [SUM_W-1:0]         band_lo_sum,
  output logic [SUM_W-1:0]         band_hi_sum,
  output logic                     frame_misaligned
);
  logic [BIN_W-1:0] bin_cnt;
  logic             first_beat;
  logic             frame_end;
  logic [E_W-1:0]   energy;
  logic [SUM_W-1:0] band_next [2];
  logic             hi_wins;

  assign s_tready  = 1'b1;
  assign frame_end = s_tvalid && s_tlast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_cnt    <= '0;
      first_beat <= 1'b1;
    end else if (s_tvalid) begin
      bin_cnt    <= s_tlast ? '0 : bin_cnt + 1'b1;
      first_beat <= s_tlast;
    end
  end

  tbd_bin_energy #(.DATA_W(DATA_W)) u_energy (
    .re(s_tre), .im(s_tim), .energy(energy)
  );

  for (genvar g = 0; g < 2; g++) begin : g_band
    tbd_band_acc #(
      .BIN_W (BIN_W),
      .CENTER((g == 0) ? CENTER_LO : CENTER_HI),
      .WINDOW(WINDOW),
      .HALF  (FRAME_LEN / 2),
      .E_W   (E_W),
      .S_W   (SUM_W)
    ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat    (s_tvalid),
      .first   (first_beat),
      .bin     (bin_cnt),
      .energy  (energy),
      .sum_next(band_next[g])
    );
  end

  tbd_decide #(.S_W(SUM_W), .MARGIN(MARGIN)) u_decide (
    .lo_sum (band_next[0]),
    .hi_sum (band_next[1]),
    .hi_wins(hi_wins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_bit         <= 1'b0;
      band_lo_sum      <= '0;
      band_hi_sum      <= '0;
      frame_misaligned <= 1'b0;
    end else if (frame_end) begin
      tone_bit         <= hi_wins;
      band_lo_sum      <= band_next[0];
      band_hi_sum      <= band_next[1];
      frame_misaligned <= (bin_cnt != BIN_W'(FRAME_LEN - 1));
    end
  end
endmodule

// File: rtl/tbd_checker.sv
module tbd_checker #(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 8192,
  parameter int WINDOW    = 4,
  parameter int MARGIN    = 2,
  parameter int SUM_W     = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_tvalid,
  input logic             s_tready,
  input logic             s_tlast,
  input logic             tone_bit,
  input logic [SUM_W-1:0] band_lo_sum,
  input logic [SUM_W-1:0] band_hi_sum,
  input logic             frame_misaligned
);
  localparam longint BAND_MAX = longint'(2 * WINDOW + 1) <<< DATA_W;

  int unsigned beat_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat_idx <= 0;
    else if (s_tvalid) beat_idx <= s_tlast ? 0 : beat_idx + 1;
  end

  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n) s_tready);

  p_hold_when_no_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_tvalid && s_tlast) |=> ($stable(tone_bit) && $stable(band_lo_sum)
                                && $stable(band_hi_sum) && $stable(frame_misaligned)));

  p_bit_matches_sums_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tone_bit == (longint'(band_hi_sum) > longint'(band_lo_sum) * MARGIN));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'(band_lo_sum) <= BAND_MAX) && (longint'(band_hi_sum) <= BAND_MAX));

  p_misalign_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tlast) |=> (frame_misaligned == $past(beat_idx != FRAME_LEN - 1)));
endmodule

bind tone_band_detector tbd_checker #(
  .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .WINDOW(WINDOW),
  .MARGIN(MARGIN), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .s_tlast(s_tlast), .tone_bit(tone_bit), .band_lo_sum(band_lo_sum),
  .band_hi_sum(band_hi_sum), .frame_misaligned(frame_misaligned)
);

// File: tb/sim_tone_band_detector.sv
module sim_tone_band_detector;
  localparam int DW = 16, FL = 64, CLO = 10, CHI = 31, WIN = 2, MRG = 2;
  localparam int SW = DW + 1 + $clog2(2 * WIN + 1);

  typedef struct packed {
    logic signed [15:0] lo_re, lo_im, hi_re, hi_im, other;
    logic [7:0] len;
    logic       gaps;
  } vec_t;

  // Low-band bins 8..12 get lo_*, bins 29..33 get hi_*, all others get other/0.
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'sd100, -16'sd50, 16'sd0, 16'sd0, 16'sd7, 8'd64, 1'b0},
    '{16'sd10, 16'sd0, 16'sd30, 16'sd0, 16'sd7, 8'd64, 1'b0},
    '{16'sd10, 16'sd0, 16'sd40, -16'sd20, -16'sd3, 8'd64, 1'b1},
    '{16'sd30, 16'sd0, 16'sd100, 16'sd0, 16'sd0, 8'd64, 1'b0},
    '{16'sd30, 16'sd0, 16'sd101, 16'sd0, 16'sd0, 8'd64, 1'b1},
    '{16'sh8000, 16'sh8000, 16'sh8000, 16'sh8000, 16'sd0, 8'd64, 1'b0},
    '{16'sd0, 16'sd0, 16'sd1, 16'sd0, 16'sd9, 8'd64, 1'b0},
    '{16'sd5, 16'sd5, 16'sd0, 16'sd0, 16'sd0, 8'd40, 1'b0},
    '{16'sd1, 16'sd1, 16'sd1, 16'sd1, 16'sd0, 8'd64, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic s_tvalid = 0, s_tlast = 0;
  logic signed [DW-1:0] s_tre = '0, s_tim = '0;
  logic s_tready, tone_bit, frame_misaligned;
  logic [SW-1:0] band_lo_sum, band_hi_sum;

  int checks = 0, fails = 0;
  logic        prev_bit = 0, prev_mis = 0;
  longint      prev_lo = 0, prev_hi = 0;

  always #10 clk = ~clk;

  tone_band_detector #(.DATA_W(DW), .FRAME_LEN(FL), .CENTER_LO(CLO), .CENTER_HI(CHI),
                       .WINDOW(WIN), .MARGIN(MRG)) u0 (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tre(s_tre), .s_tim(s_tim), .s_tlast(s_tlast), .tone_bit(tone_bit),
    .band_lo_sum(band_lo_sum), .band_hi_sum(band_hi_sum),
    .frame_misaligned(frame_misaligned));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_held(input string req);
    check({req, " bit held"}, tone_bit, prev_bit);
    check({req, " lo held"}, band_lo_sum, prev_lo);
    check({req, " hi held"}, band_hi_sum, prev_hi);
    check({req, " flag held"}, frame_misaligned, prev_mis);
  endtask

  function automatic longint mag(input logic signed [15:0] v);
    return (v < 0) ? -longint'(v) : longint'(v);
  endfunction

  task automatic send_frame(input vec_t v);
    longint elo = 0, ehi = 0;
    logic signed [15:0] r, m;
    for (int i = 0; i < int'(v.len); i++) begin
      if (i >= CLO - WIN && i <= CLO + WIN) begin r = v.lo_re; m = v.lo_im; end
      else if (i >= CHI - WIN && i <= CHI + WIN) begin r = v.hi_re; m = v.hi_im; end
      else begin r = v.other; m = 0; end
      // Model per R2, R3, R4.
      if (i >= CLO - WIN && i <= CLO + WIN && i < FL / 2) elo += mag(r) + mag(m);
      if (i >= CHI - WIN && i <= CHI + WIN && i < FL / 2) ehi += mag(r) + mag(m);
      if (v.gaps && (i % 3 == 2)) begin
        @(negedge clk); s_tvalid = 0; s_tlast = 1;
      end
      @(negedge clk);
      if (i == int'(v.len) / 2) check_held("R6 mid-frame");
      s_tvalid = 1; s_tre = r; s_tim = m; s_tlast = (i == int'(v.len) - 1);
    end
    @(negedge clk);
    s_tvalid = 0; s_tlast = 0;
    check("R3 lo sum", band_lo_sum, elo);
    check("R3/R4 hi sum", band_hi_sum, ehi);
    check("R5 decision", tone_bit, (ehi > MRG * elo) ? 1 : 0);
    check("R8 misaligned", frame_misaligned, (v.len != FL) ? 1 : 0);
    check("R1 ready", s_tready, 1);
    prev_bit = tone_bit; prev_lo = band_lo_sum; prev_hi = band_hi_sum;
    prev_mis = frame_misaligned;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset bit", tone_bit, 0);
    check("R10 reset lo", band_lo_sum, 0);
    check("R10 reset hi", band_hi_sum, 0);
    check("R10 reset flag", frame_misaligned, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready after reset", s_tready, 1);

    for (int k = 0; k < NV; k++) send_frame(VECS[k]);

    // R9: full-scale frame (vector 5) gives exact sums 5*2^16 and 3*2^16.
    send_frame(VECS[5]);
    check("R9 lo full scale", band_lo_sum, 5 * 65536);
    check("R9 hi full scale", band_hi_sum, 3 * 65536);

    // R7: quiet frame right after full scale must read zero sums.
    send_frame('{16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 8'd64, 1'b0});
    check("R7 cleared lo", band_lo_sum, 0);
    check("R7 cleared hi", band_hi_sum, 0);

    // R1: end marker with valid low is ignored.
    send_frame(VECS[2]);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); s_tvalid = 0; s_tlast = 1; s_tre = 16'sd999; s_tim = 16'sd999;
    end
    @(negedge clk); s_tlast = 0;
    check_held("R1 idle last");
    // R1: no bin counted while idle, so a 64-beat frame is still aligned.
    send_frame(VECS[0]);
    check("R1 no idle count", frame_misaligned, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule